// File: doc/BRIEF.md
# Two-Wire Target Presence Probe

This block sits on the controller side of a two-wire serial bus and checks whether a chosen target device is present. It pulls SCL and SDA low through open-drain enable outputs and reads the SDA line back. A single-cycle address strobe starts it. The block then makes repeated probe attempts. Each attempt is a START condition, the address bytes in write direction, one acknowledge slot per byte, and a STOP condition. When the target acknowledges the final address byte, the block emits a one-cycle ready pulse for the interrupt logic and goes back to idle.

After an attempt that gets no acknowledge, the block waits a programmable number of whole SCL periods and then tries again. It keeps retrying until an acknowledge arrives or software withdraws the enables. Bus timing comes from a `tick` pulse supplied by the surrounding clock divider. One SCL period is four ticks. The block does no data transfer and no arbitration, and it never waits on a held-low clock.

Top module: `i2c_presence_probe`

## Requirements
- R1: After reset, both line enables (`scl_oe`, `sda_oe`) are 0, so both lines are released, and `slave_ready` is 0.
- R2: An attempt starts only when `addr_wr` is pulsed while `master_en` and `monitor_en` are both 1. A strobe at any other time causes no bus activity.
- R3: In short mode (`addr_short` = 1), each attempt sends one byte, MSB first: `target_addr[6:0]` followed by a 0 direction bit.
- R4: In long mode (`addr_short` = 0), the first byte is 1,1,1,1,0, then `target_addr[9:8]`, then a 0 direction bit. The second byte is `target_addr[7:0]`. Each byte has its own acknowledge slot. A missing acknowledge on the first byte ends the attempt before the second byte.
- R5: A missing acknowledge ends the attempt with STOP. The block then waits (`pause_cfg`+1) SCL periods of 4 ticks each before the next START. The time from the STOP edge to the next START edge is 4·`pause_cfg`+7 ticks, which is 7 ticks when the pause is 0.
- R6: An acknowledge on the final address byte gives exactly one `slave_ready` pulse, one clock wide. The attempt then ends with STOP, and the block stays idle until the next valid strobe.
- R7: If either enable is cleared during a byte, the block finishes the current bit, issues STOP and goes idle with no ready pulse. If an enable is cleared during the pause, the block goes idle at once and makes no further attempt.
- R8: Inside a byte or an acknowledge slot, SDA changes only while SCL is held low. Each attempt therefore shows exactly one START and one STOP.
- R9: The address, mode and pause value are captured at the strobe. Changing them during the retry sequence has no effect on the bytes sent or on the pause length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Quarter-SCL-period timing pulse |
| master_en | input | 1 | Controller role enable |
| monitor_en | input | 1 | Presence probe enable |
| addr_short | input | 1 | 1 = 7-bit address, 0 = 10-bit address |
| target_addr | input | 10 | Target address |
| pause_cfg | input | PAUSE_W | Pause between attempts, in SCL periods minus one |
| addr_wr | input | 1 | One-cycle strobe that starts probing |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| slave_ready | output | 1 | One-cycle pulse when the target acknowledges |

## Verification
The assertions assume three things about the inputs. First, `tick` is a single-cycle pulse that is never high on two consecutive clocks. Second, `addr_wr` is a single-cycle pulse. Third, `sda_i` is a wired-AND of the block's own pull and the target's pull. The bench keeps to all three. It issues a tick every fourth clock. It derives `sda_i` only from `sda_oe` and a target model. The target model pulls SDA only across an acknowledge slot: it starts pulling on the SCL falling edge that follows the eighth rising edge and releases on the next falling edge. This means the target never drives SDA while SCL is high.

// File: rtl/slvprobe_pkg.sv
`timescale 1ns/1ps
package slvprobe_pkg;

  typedef enum logic [2:0] {
    SP_IDLE,
    SP_START,
    SP_BITS,
    SP_ACK,
    SP_STOP,
    SP_PAUSE
  } probe_st_e;

  localparam int unsigned ADDR_W = 10;
  localparam logic [4:0] LONG_TAG = 5'b11110;

  // Address byte for a given byte index; direction bit is always write (0).
  function automatic logic [7:0] probe_byte(input logic short_mode,
                                            input logic idx,
                                            input logic [ADDR_W-1:0] a);
    if (short_mode)  return {a[6:0], 1'b0};
    else if (!idx)   return {LONG_TAG, a[9:8], 1'b0};
    else             return a[7:0];
  endfunction

endpackage

// File: rtl/slvprobe_phase.sv
`timescale 1ns/1ps
module slvprobe_phase #(
  parameter int unsigned PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            tick,
  output logic [PH_W-1:0] q,
  output logic            period_end
);
  localparam logic [PH_W-1:0] PH_LAST = {PH_W{1'b1}};

  logic [PH_W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (hold)      q_nx = '0;
    else if (tick) q_nx = q + 1'b1;
  end

  assign period_end = tick && !hold && (q == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

  // R8: the quarter phase advances by exactly one per tick while running
  p_phase_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && tick) |=> (q == PH_W'($past(q) + 1'b1)));

endmodule

// File: rtl/slvprobe_pause.sv
`timescale 1ns/1ps
module slvprobe_pause #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  input  logic             period_end,
  output logic             done
);
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    if (load)                                    cnt_nx = load_val;
    else if (en && period_end && (cnt != '0))    cnt_nx = cnt - 1'b1;
  end

  assign done = en && period_end && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

endmodule

// File: rtl/i2c_presence_probe.sv
`timescale 1ns/1ps
module i2c_presence_probe
  import slvprobe_pkg::*;
#(
  parameter int unsigned PAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               master_en,
  input  logic               monitor_en,
  input  logic               addr_short,
  input  logic [ADDR_W-1:0]  target_addr,
  input  logic [PAUSE_W-1:0] pause_cfg,
  input  logic               addr_wr,
  input  logic               sda_i,
  output logic               scl_oe,
  output logic               sda_oe,
  output logic               slave_ready
);
  localparam int unsigned PH_W = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  probe_st_e          st, st_nx;
  logic [2:0]         bit_idx, bit_nx;
  logic               byte_idx, byte_nx;
  logic               fin_q, fin_nx;
  logic               rdy_nx;
  logic               ack_seen;
  logic [ADDR_W-1:0]  addr_q;
  logic               short_q;
  logic [PAUSE_W-1:0] pause_q;
  logic               load_cfg, pause_load, pause_done;
  logic [PH_W-1:0]    q;
  logic               period_end;
  logic               run, last_byte, ack_smp;
  logic [7:0]         cur_byte;

  assign run       = master_en && monitor_en;
  assign last_byte = short_q ? 1'b0 : 1'b1;
  assign ack_smp   = (st == SP_ACK) && tick && (q == 2'd2);
  assign cur_byte  = probe_byte(short_q, byte_idx, addr_q);

  slvprobe_phase #(.PH_W(PH_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_q),
    .hold       (st == SP_IDLE),
    .tick       (tick),
    .q          (q),
    .period_end (period_end)
  );

  slvprobe_pause #(.CNT_W(PAUSE_W)) u_pause (
    .clk        (clk),
    .rst_n      (rst_q),
    .load       (pause_load),
    .load_val   (pause_q),
    .en         (st == SP_PAUSE),
    .period_end (period_end),
    .done       (pause_done)
  );

  // next-state logic
  always_comb begin
    st_nx      = st;
    bit_nx     = bit_idx;
    byte_nx    = byte_idx;
    fin_nx     = fin_q;
    rdy_nx     = 1'b0;
    load_cfg   = 1'b0;
    pause_load = 1'b0;
    unique case (st)
      SP_IDLE: if (addr_wr && run) begin
        st_nx    = SP_START;
        load_cfg = 1'b1;
        fin_nx   = 1'b0;
      end
      SP_START: if (period_end) begin
        if (!run) begin
          st_nx  = SP_STOP;
          fin_nx = 1'b1;
        end else begin
          st_nx   = SP_BITS;
          bit_nx  = 3'd7;
          byte_nx = 1'b0;
        end
      end
      SP_BITS: if (period_end) begin
        if (!run) begin
          st_nx  = SP_STOP;
          fin_nx = 1'b1;
        end else if (bit_idx == 3'd0) begin
          st_nx = SP_ACK;
        end else begin
          bit_nx = bit_idx - 3'd1;
        end
      end
      SP_ACK: if (period_end) begin
        if (!run) begin
          st_nx  = SP_STOP;
          fin_nx = 1'b1;
        end else if (!ack_seen) begin
          st_nx = SP_STOP;
        end else if (byte_idx == last_byte) begin
          st_nx  = SP_STOP;
          fin_nx = 1'b1;
          rdy_nx = 1'b1;
        end else begin
          st_nx   = SP_BITS;
          byte_nx = 1'b1;
          bit_nx  = 3'd7;
        end
      end
      SP_STOP: if (period_end) begin
        if (fin_q || !run) begin
          st_nx = SP_IDLE;
        end else begin
          st_nx      = SP_PAUSE;
          pause_load = 1'b1;
        end
      end
      SP_PAUSE: begin
        if (!run)            st_nx = SP_IDLE;
        else if (pause_done) st_nx = SP_START;
      end
      default: st_nx = SP_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st          <= SP_IDLE;
      bit_idx     <= 3'd7;
      byte_idx    <= 1'b0;
      fin_q       <= 1'b0;
      slave_ready <= 1'b0;
      ack_seen    <= 1'b0;
      addr_q      <= '0;
      short_q     <= 1'b1;
      pause_q     <= '0;
    end else begin
      st          <= st_nx;
      bit_idx     <= bit_nx;
      byte_idx    <= byte_nx;
      fin_q       <= fin_nx;
      slave_ready <= rdy_nx;
      if (ack_smp) ack_seen <= ~sda_i;
      if (load_cfg) begin
        addr_q  <= target_addr;
        short_q <= addr_short;
        pause_q <= pause_cfg;
      end
    end
  end

  // line drive decode: SCL high in quarters 1 and 2 of each bit
  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    unique case (st)
      SP_START: begin
        scl_oe = (q == 2'd3);
        sda_oe = (q != 2'd0);
      end
      SP_BITS: begin
        scl_oe = (q == 2'd0) || (q == 2'd3);
        sda_oe = ~cur_byte[bit_idx];
      end
      SP_ACK:  scl_oe = (q == 2'd0) || (q == 2'd3);
      SP_STOP: begin
        scl_oe = (q == 2'd0);
        sda_oe = (q < 2'd2);
      end
      default: ;
    endcase
  end

  // R6: ready is a single-cycle pulse
  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_q)
    slave_ready |=> !slave_ready);

  // R6: ready only follows a sampled acknowledge
  p_ready_acked_r6: assert property (@(posedge clk) disable iff (!rst_q)
    slave_ready |-> ack_seen);

  // R2: no attempt leaves idle without both enables
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (st == SP_IDLE && !run) |=> (st == SP_IDLE));

  // R8: SDA holds steady while SCL is released inside a byte
  p_sda_steady_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (st == SP_BITS && $past(st) == SP_BITS && !scl_oe) |-> $stable(sda_oe));

  // R7: losing an enable during the pause goes straight to idle
  p_pause_abort_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (st == SP_PAUSE && !run) |=> (st == SP_IDLE));

  // R5: an expired pause launches the next attempt
  p_pause_exit_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (st == SP_PAUSE && run && pause_done) |=> (st == SP_START));

endmodule

// File: tb/i2c_presence_probe_bench.sv
`timescale 1ns/1ps
module i2c_presence_probe_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       master_en, monitor_en, addr_short, addr_wr;
  logic [9:0] target_addr;
  logic [3:0] pause_cfg;
  logic       sda_i;
  logic       scl_oe, sda_oe, slave_ready;
  logic       scl_i;

  // open-drain bus with target model
  logic ack_drive;
  assign scl_i = ~scl_oe;
  assign sda_i = ~(sda_oe | ack_drive);

  i2c_presence_probe u_i2c_presence_probe (
    .clk(clk), .rst_n(rst_n), .tick(tick), .master_en(master_en),
    .monitor_en(monitor_en), .addr_short(addr_short), .target_addr(target_addr),
    .pause_cfg(pause_cfg), .addr_wr(addr_wr), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .slave_ready(slave_ready)
  );

  always #2.5 clk = ~clk;

  int vecs = 0;
  int fails = 0;
  bit done = 0;

  // tick every fourth clock
  initial begin
    int tc;
    tc = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = (tc == 3);
      tc = (tc + 1) % 4;
    end
  end

  // bus monitor / target
  logic mon_clr = 1'b0;
  int   nack_cfg = 0;
  int   nack_left, n_start, n_stop, n_ready, nbytes, bitcnt;
  int   cyc, last_stop, gap_last;
  bit   seen_stop, cur_ack;
  logic pscl, psda;
  logic [7:0] shreg, cap0, cap1;

  initial begin
    cyc = 0; n_start = 0; n_stop = 0; n_ready = 0; nbytes = 0; bitcnt = 0;
    ack_drive = 0; nack_left = 0; gap_last = 0; last_stop = 0; seen_stop = 0;
    cur_ack = 0; pscl = 1; psda = 1; shreg = 0; cap0 = 0; cap1 = 0;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      n_start <= 0; n_stop <= 0; n_ready <= 0; nbytes <= 0; bitcnt <= 0;
      cap0 <= 0; cap1 <= 0; gap_last <= 0; ack_drive <= 0; seen_stop <= 0;
      nack_left <= nack_cfg; pscl <= 1; psda <= 1;
    end else begin
      pscl <= scl_i;
      psda <= sda_i;
      if (slave_ready) n_ready <= n_ready + 1;
      if (pscl && scl_i && psda && !sda_i) begin
        n_start <= n_start + 1;
        bitcnt  <= 0;
        nbytes  <= 0;
        cur_ack <= (nack_left == 0);
        if (nack_left != 0) nack_left <= nack_left - 1;
        if (seen_stop) gap_last <= cyc - last_stop;
      end else if (pscl && scl_i && !psda && sda_i) begin
        n_stop    <= n_stop + 1;
        last_stop <= cyc;
        seen_stop <= 1;
      end else if (!pscl && scl_i) begin
        if (bitcnt < 8) shreg <= {shreg[6:0], sda_i};
        if (bitcnt == 7) begin
          if (nbytes == 0) cap0 <= {shreg[6:0], sda_i};
          else             cap1 <= {shreg[6:0], sda_i};
        end
        bitcnt <= bitcnt + 1;
      end else if (pscl && !scl_i) begin
        if (bitcnt == 8) ack_drive <= cur_ack;
        else if (bitcnt == 9) begin
          ack_drive <= 0;
          bitcnt    <= 0;
          nbytes    <= nbytes + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mon_reset(input int nacks);
    nack_cfg = nacks;
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic strobe(input bit shrt, input logic [9:0] a, input logic [3:0] p);
    @(negedge clk);
    addr_short = shrt; target_addr = a; pause_cfg = p; addr_wr = 1'b1;
    @(negedge clk);
    addr_wr = 1'b0;
  endtask

  task automatic t_reset;
    wait_cyc(5);
    chk(scl_oe == 0, "R1 scl_oe", scl_oe, 0);
    chk(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
    chk(slave_ready == 0, "R1 slave_ready", slave_ready, 0);
  endtask

  task automatic t_disabled;
    mon_reset(0);
    monitor_en = 1'b0;
    strobe(1, 10'h05A, 0);
    wait_cyc(300);
    chk(n_start == 0, "R2 monitor off", n_start, 0);
    monitor_en = 1'b1; master_en = 1'b0;
    strobe(1, 10'h05A, 0);
    wait_cyc(300);
    chk(n_start == 0, "R2 master off", n_start, 0);
    master_en = 1'b1;
  endtask

  task automatic t_short_ack;
    mon_reset(0);
    strobe(1, 10'h05A, 0);
    wait_cyc(300);
    chk(cap0 == 8'hB4, "R3 short byte", cap0, 8'hB4);
    chk(nbytes == 1, "R3 byte count", nbytes, 1);
    chk(n_ready == 1, "R6 ready pulses", n_ready, 1);
    chk(n_stop == 1, "R6 stop after ack", n_stop, 1);
    wait_cyc(400);
    chk(n_start == 1, "R6 idle after ready", n_start, 1);
    chk(n_start == n_stop, "R8 one start per stop", n_stop, n_start);
  endtask

  task automatic t_retry_pause;
    mon_reset(2);
    strobe(1, 10'h013, 2);
    wait_cyc(2);
    target_addr = 10'h3FF; pause_cfg = 4'hF; addr_short = 1'b0;
    wait_cyc(1000);
    chk(n_start == 3, "R5 attempts", n_start, 3);
    chk(n_stop == 3, "R8 stops", n_stop, 3);
    chk(n_ready == 1, "R6 ready after retries", n_ready, 1);
    chk(gap_last == 60, "R9 pause from strobe", gap_last, 60);
    chk(cap0 == 8'h26, "R9 address from strobe", cap0, 8'h26);
  endtask

  task automatic t_default_pause;
    mon_reset(1);
    strobe(1, 10'h07F, 0);
    wait_cyc(600);
    chk(n_start == 2, "R5 zero pause attempts", n_start, 2);
    chk(gap_last == 28, "R5 zero pause gap", gap_last, 28);
    chk(cap0 == 8'hFE, "R3 all-ones address", cap0, 8'hFE);
  endtask

  task automatic t_long_ack;
    mon_reset(0);
    strobe(0, 10'h2C7, 0);
    wait_cyc(500);
    chk(nbytes == 2, "R4 long byte count", nbytes, 2);
    chk(cap0 == 8'hF4, "R4 long first byte", cap0, 8'hF4);
    chk(cap1 == 8'hC7, "R4 long second byte", cap1, 8'hC7);
    chk(n_ready == 1, "R4 long ready", n_ready, 1);
  endtask

  task automatic t_long_nack_pause_abort;
    mon_reset(15);
    strobe(0, 10'h1A5, 15);
    wait_cyc(400);
    chk(n_start == 1 && n_stop == 1, "R4 nack first byte stop", n_stop, 1);
    chk(nbytes == 1, "R4 no second byte", nbytes, 1);
    chk(cap0 == 8'hF2, "R4 prefix byte", cap0, 8'hF2);
    monitor_en = 1'b0;
    wait_cyc(1500);
    chk(n_start == 1, "R7 pause abort", n_start, 1);
    chk(scl_oe == 0 && sda_oe == 0, "R7 lines released", {scl_oe, sda_oe}, 0);
    monitor_en = 1'b1;
    wait_cyc(300);
    chk(n_start == 1, "R7 idle until strobe", n_start, 1);
    chk(n_ready == 0, "R7 no ready", n_ready, 0);
  endtask

  task automatic t_abort_mid;
    mon_reset(0);
    strobe(1, 10'h05A, 0);
    wait_cyc(60);
    master_en = 1'b0;
    wait_cyc(400);
    chk(n_start == 1, "R7 mid-byte starts", n_start, 1);
    chk(n_stop == 1, "R7 mid-byte stop", n_stop, 1);
    chk(n_ready == 0, "R7 mid-byte no ready", n_ready, 0);
    chk(nbytes == 0, "R7 byte cut short", nbytes, 0);
    master_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; master_en = 1'b1; monitor_en = 1'b1; addr_short = 1'b1;
    target_addr = '0; pause_cfg = '0; addr_wr = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_short_ack();
    t_retry_pause();
    t_default_pause();
    t_long_ack();
    t_long_nack_pause_abort();
    t_abort_mid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule